// File: doc/BRIEF.md
# Stage-Gated Pipelined Search Memory

This block is a binary content-addressable memory whose stored words are divided into a number of equal slices, each slice sitting in its own pipeline stage. A search key enters the first stage on a clock edge and, one stage per cycle, is compared against the words of each slice in turn. A stage hands the key to its successor only while no slice so far has produced a match. Once a hit is found, the remaining stages never latch that key and never evaluate it. Their match logic stays quiet, so power follows the data rather than the array size.

The hit flag and the global address of the matching word travel down a small result pipeline beside the key. Stages that are idle for a search pass these values through unchanged. Every search produces exactly one result, which leaves the block a fixed number of cycles after issue, and results come out in issue order with one search accepted per cycle. Words are loaded through a write port that also carries a valid bit, so that an entry can be retired. At most one valid word is expected to match any given key.

Top module: `stgcam`

## Requirements
- R1: After reset, every entry is invalid, every stage-activity bit is 0 and `res_vld`, `res_hit` and `res_addr` are 0.
- R2: A search sampled on clock edge n yields `res_vld` = 1 after edge n + STAGES. Back-to-back searches give back-to-back results in issue order, and cycles with no search give `res_vld` = 0.
- R3: When a valid entry equals the key, the result has `res_hit` = 1 and `res_addr` = the entry's global index, where entry index = stage number × (DEPTH/STAGES) + position inside the stage.
- R4: When no valid entry equals the key, the result has `res_hit` = 0 and `res_addr` = 0.
- R5: `stage_act[0]` is 1 after every edge on which `srch_en` was 1, and 0 otherwise.
- R6: For a search sampled on edge n whose match lies in stage h, `stage_act[s]` is 1 after edge n + s for every s ≤ h and 0 for every s > h. With no match, every stage is active in turn.
- R7: A write with `wr_valid` = 0 retires the entry, and retired or never-written entries never match any key.
- R8: A write sampled on the same edge as a search is already visible to that search, and to every later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry index being written |
| wr_data | input | W | Word to store |
| wr_valid | input | 1 | Valid bit stored with the word |
| srch_en | input | 1 | Issue a search this cycle |
| srch_key | input | W | Search key |
| res_vld | output | 1 | A search result is present |
| res_hit | output | 1 | The search found a match |
| res_addr | output | AW | Global index of the matching entry (0 on a miss) |
| stage_act | output | STAGES | Per-stage flag: the stage loaded a key and is comparing it this cycle |

## Verification
A write and a search can land on the same clock edge, and the block promises that the search already sees the new word. The bench writes a fresh word into a last-stage entry and searches for it on the same edge, and it also retires an entry on the same edge that searches for it. The reference model applies the write before it evaluates the search, and the output pipeline must agree on every clock. The bench also checks the per-stage activity bits, so that a hit found early in the pipeline is confirmed to leave the later stages idle.

// File: rtl/stgcam.sv
module stgcam #(
  parameter int W      = 8,
  parameter int DEPTH  = 16,
  parameter int STAGES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic                     wr_valid,
  input  logic                     srch_en,
  input  logic [W-1:0]             srch_key,
  output logic                     res_vld,
  output logic                     res_hit,
  output logic [$clog2(DEPTH)-1:0] res_addr,
  output logic [STAGES-1:0]        stage_act
);
  localparam int PER = DEPTH / STAGES;
  localparam int AW  = $clog2(DEPTH);

  logic [W-1:0]      mem [DEPTH];
  logic [DEPTH-1:0]  ent_v;
  logic [STAGES-1:0] act, vld, hit, mt_any, hit_o;
  logic [W-1:0]      key   [STAGES];
  logic [AW-1:0]     adr   [STAGES];
  logic [AW-1:0]     mt_adr[STAGES];
  logic [AW-1:0]     adr_o [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ent_v <= '0;
    else if (wr_en) ent_v[wr_addr] <= wr_valid;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic          m;
    logic [AW-1:0] ma;
    always_comb begin
      m  = 1'b0;
      ma = '0;
      for (int j = PER - 1; j >= 0; j--)
        if (act[s] && ent_v[s*PER+j] && mem[s*PER+j] == key[s]) begin
          m  = 1'b1;
          ma = AW'(s*PER + j);
        end
    end
    assign mt_any[s] = m;
    assign mt_adr[s] = ma;
    assign hit_o[s]  = hit[s] | m;
    assign adr_o[s]  = hit[s] ? adr[s] : ma;

    if (s > 0) begin : g_chk
      // R6
      chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act[s] |-> $past(act[s-1]));
      // R6
      gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act[s-1] && mt_any[s-1]) |=> !act[s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= '0; vld <= '0; hit <= '0;
      for (int s = 0; s < STAGES; s++) begin
        key[s] <= '0;
        adr[s] <= '0;
      end
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_addr <= '0;
    end else begin
      act[0] <= srch_en;
      vld[0] <= srch_en;
      hit[0] <= 1'b0;
      adr[0] <= '0;
      if (srch_en) key[0] <= srch_key;
      for (int s = 1; s < STAGES; s++) begin
        act[s] <= vld[s-1] & ~hit_o[s-1];
        vld[s] <= vld[s-1];
        hit[s] <= hit_o[s-1];
        adr[s] <= adr_o[s-1];
        if (vld[s-1] && !hit_o[s-1]) key[s] <= key[s-1];
      end
      res_vld  <= vld[STAGES-1];
      res_hit  <= vld[STAGES-1] & hit_o[STAGES-1];
      res_addr <= vld[STAGES-1] ? adr_o[STAGES-1] : '0;
    end

  assign stage_act = act;

  // R5
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> stage_act[0]);
  // R2
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld[STAGES-1] |=> res_vld);
  // R3
  hitvld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_vld);
  // R4
  missaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_addr == '0);
endmodule

// File: tb/sim_stgcam.sv
`timescale 1ns/1ps
module sim_stgcam;
  localparam int W = 8, DEPTH = 16, N = 4, PER = DEPTH / N, AW = 4, RING = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, srch_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0, srch_key = '0;
  logic res_vld, res_hit;
  logic [AW-1:0] res_addr;
  logic [N-1:0]  stage_act;

  always #4 clk = ~clk;

  stgcam #(.W(W), .DEPTH(DEPTH), .STAGES(N)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_valid,
    .srch_en, .srch_key, .res_vld, .res_hit, .res_addr, .stage_act);

  int vectors = 0, errors = 0, cyc = 0;
  logic [W-1:0]  m_data [DEPTH];
  logic          m_v    [DEPTH];
  logic [N-1:0]  e_act  [RING];
  logic          e_rv   [RING];
  logic          e_rh   [RING];
  logic [AW-1:0] e_ra   [RING];

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    for (int i = 0; i < RING; i++) begin
      e_act[i] = '0; e_rv[i] = 0; e_rh[i] = 0; e_ra[i] = '0;
    end
  endtask

  task automatic issue(int n, logic [W-1:0] k);
    int idx = -1, h;
    for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_data[i] == k) idx = i;
    h = (idx < 0) ? N : idx / PER;
    for (int s = 0; s < N; s++) if (s <= h) e_act[(n+s)%RING][s] = 1'b1;
    e_rv[(n+N)%RING] = 1;
    e_rh[(n+N)%RING] = (idx >= 0);
    e_ra[(n+N)%RING] = (idx >= 0) ? AW'(idx) : '0;
  endtask

  task automatic step(logic we, logic [AW-1:0] wa, logic [W-1:0] wd, logic wv,
                      logic se, logic [W-1:0] k);
    int sl;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_valid = wv;
    srch_en = se; srch_key = k;
    if (we) begin m_data[wa] = wd; m_v[wa] = wv; end   // R8: write before search
    if (se) issue(cyc + 1, k);
    @(posedge clk);
    cyc++;
    @(negedge clk);
    sl = cyc % RING;
    vectors++;
    if (stage_act !== e_act[sl]) begin
      errors++;
      $display("FAIL R5 R6 cyc %0d stage_act act=%b exp=%b", cyc, stage_act, e_act[sl]);
    end
    vectors++;
    if (res_vld !== e_rv[sl] || res_hit !== e_rh[sl] || res_addr !== e_ra[sl]) begin
      errors++;
      $display("FAIL R2 R3 R4 cyc %0d result act=%b/%b/%0d exp=%b/%b/%0d",
               cyc, res_vld, res_hit, res_addr, e_rv[sl], e_rh[sl], e_ra[sl]);
    end
    e_act[sl] = '0; e_rv[sl] = 0; e_rh[sl] = 0; e_ra[sl] = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, '0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle(3);                                   // R1 reset state
    for (int i = 0; i < DEPTH; i++) step(1, AW'(i), W'(i*13+5), 1, 0, '0);
    idle(2);
    for (int i = 0; i < DEPTH; i++) step(0, '0, '0, 0, 1, W'(i*13+5));   // R3 R6
    for (int i = 0; i < 3; i++) step(0, '0, '0, 0, 1, 8'hFF);            // R4
    for (int i = DEPTH - 1; i >= 0; i -= 3) begin                         // R2 gaps
      step(0, '0, '0, 0, 1, W'(i*13+5));
      idle(i % 2);
    end
    idle(N + 1);
    step(1, 4'd5, 8'h42, 0, 0, '0);            // R7 retire entry 5
    idle(N + 1);
    step(0, '0, '0, 0, 1, 8'h42);              // R7 retired word misses
    step(0, '0, '0, 0, 1, W'(5*13+5));         // R7 old word misses
    idle(N + 1);
    step(1, 4'd14, 8'hEE, 1, 1, 8'hEE);        // R8 same-edge write, stage 3
    step(1, 4'd2, 8'h31, 0, 1, W'(2*13+5));    // R8 same-edge retire
    step(0, '0, '0, 0, 1, 8'hEE);
    step(0, '0, '0, 0, 1, W'(14*13+5));
    idle(N + 1);
    do_reset();                                // R1 entries cleared
    idle(1);
    for (int i = 0; i < 4; i++) step(0, '0, '0, 0, 1, W'(i*4*13+5));     // R7 never written
    step(1, 4'd0, 8'h77, 1, 0, '0);
    step(0, '0, '0, 0, 1, 8'h77);
    idle(N + 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule